// File: doc/BRIEF.md
# Triggered quadrature decoder counter

This block turns the two phase signals of an incremental encoder, together with its once-per-revolution index line, into a signed 16-bit position count, a direction flag, a one-cycle step pulse for every accepted phase edge and a one-cycle index pulse. Each of the three encoder lines can have its polarity inverted on its own. Every line then passes through a two-stage synchronizer and a glitch filter before the edge decoder sees it.

Counting is gated twice. A run status, set or cleared by writes to a clock-enable control, stands for the decoder clock. Counting also has to be started by a trigger. A trigger is either a software strobe or an external event, and the event counts only when its enable bit is set. A trigger clears the position and the error flag, loads the filters with the present input levels, and arms the counter. A step in which both phases move at once cannot be decoded. Such a step leaves the position alone and sets a sticky error flag.

Top module: `qdec_trig_counter`

## Requirements
- R1: A trigger clears `pos_o` and `err_o` to zero at the next clock edge. No count is made until a trigger has armed the block. Writing the clock enable to 0 disarms it again.
- R2: A high on `sw_trig_i` for one clock cycle is a trigger.
- R3: A high on `evt_i` is a trigger only while `evt_trig_en_i` is 1. While `evt_trig_en_i` is 0 it leaves the position unchanged.
- R4: Each accepted change of exactly one filtered phase moves `pos_o` by one and raises `step_o` for one cycle, in the same cycle. A full encoder cycle gives four counts.
- R5: With the phases written as {A,B}, the order 00→01→11→10→00 increments the count and sets `dir_o` to 1. The reverse order decrements it and sets `dir_o` to 0.
- R6: `idx_o` is a one-cycle pulse on each filtered rising edge of the effective index level, while counting is active.
- R7: `inv_a_i`, `inv_b_i` and `inv_idx_i` each invert their own input before the synchronizer. Toggling one of them while counting therefore acts as an edge on that line.
- R8: A cycle with `clk_en_wr_i`=1 loads `run_o` with `clk_en_val_i`. While `run_o` is 0 the position does not change except through a trigger.
- R9: A new level on an input is accepted only after it has been stable for 3 consecutive active cycles after the 2-flop synchronizer. A pulse of 2 cycles is dropped. A clean edge shows on `pos_o` 6 clock edges after the input changes.
- R10: A filtered step in which both A and B change leaves `pos_o` unchanged, raises no step pulse and sets `err_o`. `err_o` stays set until a trigger or reset.
- R11: The position wraps modulo 2^16: one decrement from 0 gives 16'hFFFF, and one increment from 16'hFFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a_i | input | 1 | Encoder phase A |
| enc_b_i | input | 1 | Encoder phase B |
| enc_idx_i | input | 1 | Encoder index |
| inv_a_i | input | 1 | Invert phase A |
| inv_b_i | input | 1 | Invert phase B |
| inv_idx_i | input | 1 | Invert index |
| clk_en_wr_i | input | 1 | Write strobe for the clock-enable control |
| clk_en_val_i | input | 1 | Value written to the clock-enable control |
| sw_trig_i | input | 1 | Software trigger strobe |
| evt_i | input | 1 | External event strobe |
| evt_trig_en_i | input | 1 | Allows the event to act as a trigger |
| pos_o | output | 16 | Position count |
| dir_o | output | 1 | Last step direction, 1 = increment |
| step_o | output | 1 | One-cycle pulse per counted step |
| idx_o | output | 1 | One-cycle index pulse |
| run_o | output | 1 | Clock-running status |
| err_o | output | 1 | Sticky illegal-transition flag |

## Verification
A table of phase states first walks the Gray sequence forward through a whole encoder cycle, then backward through zero into 16'hFFFF and back. This separates increment from decrement and checks the direction flag and the wrap. Toggles made before any trigger, or with the run status cleared, must leave the count alone; this separates the two gating conditions. A two-cycle pulse against a clean edge tests the filter length, and a change of both phases at once tests the illegal-step path. Polarity bits are toggled on their own to show that each acts only on its own line, and the event is sent once with its enable low and once with it high to confirm the enable works.

// File: rtl/qdec_pkg.sv
// Package: shared constants and types of the triggered quadrature decoder.
// Assumes: input vectors are ordered {index, B, A}, bit 0 being phase A.
package qdec_pkg;
    parameter int QDEC_CNT_W       = 16;
    parameter int QDEC_FILT_LEN    = 3;
    parameter int QDEC_SYNC_STAGES = 2;

    localparam int QDEC_LINES = 3;
    localparam int LN_A   = 0;
    localparam int LN_B   = 1;
    localparam int LN_IDX = 2;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_BAD  = 2'd3
    } step_kind_e;
endpackage

// File: rtl/qdec_sync.sv
// Module: multi-flop synchronizer for a vector of asynchronous lines.
// Assumes: each bit is independent; no bus coherency is needed.
module qdec_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift each line one flop deeper per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= din;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_filter.sv
// Module: per-line glitch filter. A new level is taken only after it has
// differed from the held level for LEN consecutive enabled cycles.
// Assumes: 'load' takes priority and copies din straight into the output.
module qdec_filter #(
    parameter int W   = 3,
    parameter int LEN = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            logic [CW-1:0] cnt_q;
            logic          lvl_q;

            // Purpose: count stable cycles of a differing level, then take it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                    lvl_q <= 1'b0;
                end else if (load) begin
                    cnt_q <= '0;
                    lvl_q <= din[i];
                end else if (en) begin
                    if (din[i] == lvl_q) begin
                        cnt_q <= '0;
                    end else if (cnt_q == LAST) begin
                        cnt_q <= '0;
                        lvl_q <= din[i];
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end

            assign dout[i] = lvl_q;
        end
    endgenerate
endmodule

// File: rtl/qdec_decoder.sv
// Module: step decoder and position counter. Compares the filtered lines
// with their previous values, counts Gray steps and flags illegal ones.
// Assumes: 'clr' (trigger) takes priority over 'en'; init is the level set
// that the filters are loaded with in the same cycle.
module qdec_decoder
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  clr,
    input  logic [QDEC_LINES-1:0] init,
    input  logic [QDEC_LINES-1:0] filt,
    output logic [CNT_W-1:0]      pos,
    output logic                  dir,
    output logic                  step,
    output logic                  idx,
    output logic                  err
);
    logic [QDEC_LINES-1:0] prev_q;
    step_kind_e            kind;

    // Purpose: classify the change between previous and current phases.
    always_comb begin
        unique case ({filt[LN_A] ^ prev_q[LN_A], filt[LN_B] ^ prev_q[LN_B]})
            2'b00:   kind = STEP_NONE;
            2'b11:   kind = STEP_BAD;
            default: kind = (prev_q[LN_A] ^ filt[LN_B]) ? STEP_INC : STEP_DEC;
        endcase
    end

    // Purpose: update position, direction, pulses and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pos    <= '0;
            dir    <= 1'b0;
            step   <= 1'b0;
            idx    <= 1'b0;
            err    <= 1'b0;
        end else if (clr) begin
            prev_q <= init;
            pos    <= '0;
            step   <= 1'b0;
            idx    <= 1'b0;
            err    <= 1'b0;
        end else begin
            step <= 1'b0;
            idx  <= 1'b0;
            if (en) begin
                prev_q <= filt;
                idx    <= filt[LN_IDX] & ~prev_q[LN_IDX];
                unique case (kind)
                    STEP_INC: begin
                        pos  <= pos + 1'b1;
                        dir  <= 1'b1;
                        step <= 1'b1;
                    end
                    STEP_DEC: begin
                        pos  <= pos - 1'b1;
                        dir  <= 1'b0;
                        step <= 1'b1;
                    end
                    STEP_BAD: err <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/qdec_trig_counter.sv
// Module: top of the triggered quadrature decoder. Applies input polarity,
// keeps run/armed state, forms the trigger and wires sync, filter, decoder.
// Assumes: all control inputs are synchronous to clk; encoder lines are not.
module qdec_trig_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W       = QDEC_CNT_W,
    parameter int FILT_LEN    = QDEC_FILT_LEN,
    parameter int SYNC_STAGES = QDEC_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a_i,
    input  logic             enc_b_i,
    input  logic             enc_idx_i,
    input  logic             inv_a_i,
    input  logic             inv_b_i,
    input  logic             inv_idx_i,
    input  logic             clk_en_wr_i,
    input  logic             clk_en_val_i,
    input  logic             sw_trig_i,
    input  logic             evt_i,
    input  logic             evt_trig_en_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             dir_o,
    output logic             step_o,
    output logic             idx_o,
    output logic             run_o,
    output logic             err_o
);
    logic [QDEC_LINES-1:0] eff_in;
    logic [QDEC_LINES-1:0] sync_in;
    logic [QDEC_LINES-1:0] filt_in;
    logic                  run_q;
    logic                  armed_q;
    logic                  trig;
    logic                  active;

    // Purpose: apply per-line polarity before synchronizing.
    assign eff_in = {enc_idx_i ^ inv_idx_i, enc_b_i ^ inv_b_i, enc_a_i ^ inv_a_i};

    // Purpose: merge the software strobe and the gated event into a trigger.
    assign trig   = sw_trig_i | (evt_i & evt_trig_en_i);
    assign active = run_q & armed_q;

    // Purpose: clock-running status, set and cleared by control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else if (clk_en_wr_i) run_q <= clk_en_val_i;
    end

    // Purpose: armed by a trigger, disarmed by a clock-disable write.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else if (clk_en_wr_i && !clk_en_val_i) armed_q <= 1'b0;
        else if (trig) armed_q <= 1'b1;
    end

    qdec_sync #(.W(QDEC_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (eff_in),
        .dout (sync_in)
    );

    qdec_filter #(.W(QDEC_LINES), .LEN(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active),
        .load (trig),
        .din  (sync_in),
        .dout (filt_in)
    );

    qdec_decoder #(.CNT_W(CNT_W)) u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active),
        .clr  (trig),
        .init (sync_in),
        .filt (filt_in),
        .pos  (pos_o),
        .dir  (dir_o),
        .step (step_o),
        .idx  (idx_o),
        .err  (err_o)
    );

    assign run_o = run_q;
endmodule

// File: rtl/qdec_checker.sv
// Module: property checker for qdec_trig_counter, bound to every instance.
// Assumes: observes top-level ports only.
module qdec_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en_wr_i,
    input logic             clk_en_val_i,
    input logic             sw_trig_i,
    input logic             evt_i,
    input logic             evt_trig_en_i,
    input logic [CNT_W-1:0] pos_o,
    input logic             dir_o,
    input logic             step_o,
    input logic             idx_o,
    input logic             run_o,
    input logic             err_o
);
    logic trig_seen;
    assign trig_seen = sw_trig_i | (evt_i & evt_trig_en_i);

    // R1, R2, R3: a trigger clears the count and the error flag.
    a_r1_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trig_seen |=> (pos_o == '0) && !err_o);

    // R4: a step pulse comes with a move of exactly one.
    a_r4_step_unit: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> (pos_o == CNT_W'($past(pos_o) + 1'b1)) ||
                   (pos_o == CNT_W'($past(pos_o) - 1'b1)));

    // R4: the count moves only with a step pulse or after a trigger.
    a_r4_no_silent_move: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o != $past(pos_o)) |-> (step_o || $past(trig_seen)));

    // R5: the direction flag matches the sign of the step.
    a_r5_dir_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && dir_o) |-> (pos_o == CNT_W'($past(pos_o) + 1'b1)));

    // R6: the index pulse lasts a single cycle.
    a_r6_idx_single: assert property (@(posedge clk) disable iff (!rst_n)
        idx_o |=> !idx_o);

    // R8: clock-enable writes set and clear the run status.
    a_r8_run_set: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_wr_i && clk_en_val_i) |=> run_o);
    a_r8_run_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_wr_i && !clk_en_val_i) |=> !run_o);

    // R8: with the run status low, only a trigger can change the count.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !trig_seen) |=> $stable(pos_o));

    // R10: the error flag holds until a trigger.
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !trig_seen) |=> err_o);
endmodule

bind qdec_trig_counter qdec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en_wr_i  (clk_en_wr_i),
    .clk_en_val_i (clk_en_val_i),
    .sw_trig_i    (sw_trig_i),
    .evt_i        (evt_i),
    .evt_trig_en_i(evt_trig_en_i),
    .pos_o        (pos_o),
    .dir_o        (dir_o),
    .step_o       (step_o),
    .idx_o        (idx_o),
    .run_o        (run_o),
    .err_o        (err_o)
);

// File: tb/sim_qdec_trig_counter.sv
`timescale 1ns/1ps
module sim_qdec_trig_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic        inv_a = 1'b0, inv_b = 1'b0, inv_idx = 1'b0;
    logic        en_wr = 1'b0, en_val = 1'b0;
    logic        sw_trig = 1'b0, evt = 1'b0, evt_en = 1'b0;
    logic [15:0] pos;
    logic        dir, step, idx, run, err;

    int errors = 0;
    int checks = 0;
    int step_cnt = 0;
    int idx_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    qdec_trig_counter u0 (
        .clk(clk), .rst_n(rst_n),
        .enc_a_i(enc_a), .enc_b_i(enc_b), .enc_idx_i(enc_idx),
        .inv_a_i(inv_a), .inv_b_i(inv_b), .inv_idx_i(inv_idx),
        .clk_en_wr_i(en_wr), .clk_en_val_i(en_val),
        .sw_trig_i(sw_trig), .evt_i(evt), .evt_trig_en_i(evt_en),
        .pos_o(pos), .dir_o(dir), .step_o(step), .idx_o(idx),
        .run_o(run), .err_o(err)
    );

    // Pulse monitors sampled away from the active edge.
    always @(negedge clk) begin
        if (step) step_cnt++;
        if (idx)  idx_cnt++;
    end

    // Phase table: {A, B, expected dir, expected pos}, starting from {A,B}=00, pos 0.
    localparam logic [18:0] VEC [12] = '{
        {2'b01, 1'b1, 16'h0001}, {2'b11, 1'b1, 16'h0002},
        {2'b10, 1'b1, 16'h0003}, {2'b00, 1'b1, 16'h0004},
        {2'b01, 1'b1, 16'h0005}, {2'b00, 1'b0, 16'h0004},
        {2'b10, 1'b0, 16'h0003}, {2'b11, 1'b0, 16'h0002},
        {2'b01, 1'b0, 16'h0001}, {2'b00, 1'b0, 16'h0000},
        {2'b10, 1'b0, 16'hFFFF}, {2'b00, 1'b1, 16'h0000}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic pulse_sw;
        sw_trig = 1'b1; tick(1); sw_trig = 1'b0; tick(1);
    endtask

    task automatic write_en(input logic v);
        en_wr = 1'b1; en_val = v; tick(1); en_wr = 1'b0; tick(1);
    endtask

    initial begin
        int base;
        tick(3);
        // Reset state.
        chk({pos, dir, step, idx, run, err}, 21'h0, "reset: outputs all zero (R1 R8)");
        rst_n = 1'b1;
        tick(2);

        write_en(1'b1);
        chk(run, 1'b1, "R8 run_o set by clock-enable write");

        // Not armed yet: edge on A must not count.
        enc_a = 1'b1; tick(10);
        chk(pos, 16'h0, "R1 no count before trigger");
        enc_a = 1'b0; tick(10);

        // Software trigger arms; walk the phase table.
        pulse_sw();
        chk(pos, 16'h0, "R2 software trigger clears count");
        base = step_cnt;
        for (int i = 0; i < 12; i++) begin
            enc_a = VEC[i][18];
            enc_b = VEC[i][17];
            tick(8);
            chk(pos, VEC[i][15:0], $sformatf("R5 R11 table step %0d position", i));
            chk(dir, VEC[i][16], $sformatf("R5 table step %0d direction", i));
        end
        chk(step_cnt - base, 12, "R4 one step pulse per transition");

        // Move to 01 (pos 1), then event with enable low and high.
        enc_b = 1'b1; tick(8);
        chk(pos, 16'h1, "R4 count after single step");
        evt = 1'b1; tick(1); evt = 1'b0; tick(2);
        chk(pos, 16'h1, "R3 event ignored while enable is 0");
        evt_en = 1'b1; evt = 1'b1; tick(1); evt = 1'b0; evt_en = 1'b0; tick(2);
        chk(pos, 16'h0, "R3 enabled event triggers clear");

        // Glitch of two cycles on B is dropped.
        base = step_cnt;
        enc_b = 1'b0; tick(2); enc_b = 1'b1; tick(10);
        chk(pos, 16'h0, "R9 two-cycle pulse ignored");
        chk(step_cnt - base, 0, "R9 no step pulse from glitch");

        // Clean edge timing: position updates 6 edges after the change.
        enc_b = 1'b0; tick(5);
        chk(pos, 16'h0, "R9 not yet counted after 5 edges");
        tick(1);
        chk(pos, 16'hFFFF, "R9 counted on 6th edge (R11 wrap)");
        enc_b = 1'b1; tick(8);
        chk(pos, 16'h0, "R11 increment from FFFF wraps to 0");

        // Index pulse on rising edge only.
        base = idx_cnt;
        enc_idx = 1'b1; tick(8);
        chk(idx_cnt - base, 1, "R6 index rising edge pulses once");
        enc_idx = 1'b0; tick(8);
        chk(idx_cnt - base, 1, "R6 no pulse on index falling edge");
        inv_idx = 1'b1; tick(8);
        chk(idx_cnt - base, 2, "R7 index inversion acts as rising edge");
        inv_idx = 1'b0; tick(8);

        // Phase A inversion: raw 01 -> effective 11, an increment.
        inv_a = 1'b1; tick(8);
        chk(pos, 16'h1, "R7 inverting A gives one increment");

        // Both phases change: effective 11 -> 00.
        base = step_cnt;
        enc_a = 1'b1; enc_b = 1'b0; tick(8);
        chk(pos, 16'h1, "R10 double change leaves count");
        chk(err, 1'b1, "R10 error flag set");
        chk(step_cnt - base, 0, "R10 no step pulse on illegal change");
        enc_b = 1'b1; tick(8);
        chk(pos, 16'h2, "R10 counting continues after error");
        chk(err, 1'b1, "R10 error flag sticky");
        pulse_sw();
        chk({pos, 1'b0, err}, 18'h0, "R1 trigger clears count and error");

        // Clock disable: run clears and counting stops.
        write_en(1'b0);
        chk(run, 1'b0, "R8 run_o cleared by clock-disable write");
        enc_b = 1'b0; tick(8);
        chk(pos, 16'h0, "R8 no count while run_o is 0");
        write_en(1'b1);
        enc_b = 1'b1; tick(8);
        chk(pos, 16'h0, "R1 disarmed after disable until next trigger");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule